// File: doc/BRIEF.md
# Memory-Mapped Serial Port with Masked Interrupt

The block is a serial port behind a simple 32-bit register bus. Software sends a character by writing the transmit data register. It collects received characters from the receive data register. The status register reports readiness, line events and errors. The control register selects which status flags raise the single level interrupt. It also forces a break on the outgoing line and drives the request-to-send output. The serial format is one start bit, 8 data bits sent least significant bit first, no parity and one stop bit. Every bit lasts a programmable number of system clocks.

Each direction has one character of storage in front of its shift register. The receiver is a five-state machine: IDLE waits for a low line, START confirms the start bit half a bit later, DATA samples eight bits, STOP samples the stop bit, and HOLD waits for the line to return high after a low stop bit. The transitions are IDLE to START on a low line, START to IDLE on a false start, START to DATA on a confirmed start, DATA to STOP after the eighth bit, STOP to IDLE on a high stop bit, STOP to HOLD on a low one, and HOLD to IDLE when the line goes high. The transmitter is a four-state machine. It goes IDLE to START when the holding register is loaded, START to DATA after one bit time, DATA to STOP after the eighth bit, and STOP to IDLE after the stop bit.

Top module: `uart_mm_top`

## Requirements
- R1: After reset the status register (byte offset 8) reads 0x0060, which is transmitter empty plus transmit ready. The control register (offset 12) reads 0, irq is low, txd is high and rts is low.
- R2: A character received on rxd (8N1, LSB first, divisor clocks per bit) is returned in bits 7:0 of a read at offset 0 and sets receive ready (status bit 7). That read clears receive ready.
- R3: A character that completes while receive ready is set raises receive overrun (bit 3) and exception (bit 8), and its data replaces the held data.
- R4: A write to offset 4 transmits bits 7:0 on txd as start bit, eight data bits LSB first and a stop bit, each lasting the divisor value in clocks. Transmitter empty (bit 5) is clear while any character is held or shifting.
- R5: Transmit ready (bit 6) is clear while the holding register is occupied. A transmit write made then raises transmit overrun (bit 4) and exception (bit 8), and that character is never sent.
- R6: A frame whose stop bit is sampled low sets break detected (bit 2) when all data bits are zero, and sets framing error (bit 1) otherwise. Both also set exception (bit 8). After a low stop bit the receiver starts no new frame until rxd has been high.
- R7: Any write to the status register clears bits 0–4, 8, 10 and 12, and leaves receive ready, transmit ready, transmitter empty and the CTS level unchanged.
- R8: irq is high exactly when some status bit is set together with the control bit in the same position, for positions 0–8, 10 and 12. A control value of 0 masks every source.
- R9: Control bit 9 holds txd low while set. Control bit 11 drives the rts output.
- R10: The cts input passes through a two-flop synchronizer. Status bit 11 shows the synchronized level, and any change of that level sets status bit 10.
- R11: A received character equal to bits 7:0 of the end-of-packet register (offset 20) sets status bit 12.
- R12: The divisor register (offset 16) and the end-of-packet register read back the values written to them.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 5 | Byte address within the 32-byte window |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_rd | input | 1 | Read strobe; a read at offset 0 consumes the character |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for the addressed register, combinational |
| irq | output | 1 | Level interrupt |
| rxd | input | 1 | Serial receive line |
| txd | output | 1 | Serial transmit line |
| cts | input | 1 | Clear-to-send modem input, asynchronous |
| rts | output | 1 | Request-to-send modem output |

## Verification
The hardest state to reach is a transmit overrun. The holding register is emptied into the shift register one cycle after a write, so a second write must land in exactly the next cycle to be refused. A third write is then accepted and waits behind the character that is shifting. The stimulus issues these writes back to back, while a capture process on txd checks that only the first and third characters appear. Break and framing errors are reached by driving frames with a low stop bit and holding the line low longer than a frame.

// File: rtl/uart_mm_pkg.sv
package uart_mm_pkg;
    typedef enum logic [2:0] {
        RX_IDLE, RX_START, RX_DATA, RX_STOP, RX_HOLD
    } rx_state_t;

    typedef enum logic [1:0] {
        TX_IDLE, TX_START, TX_DATA, TX_STOP
    } tx_state_t;

    localparam int STAT_W = 13;
    localparam int B_PE   = 0;
    localparam int B_FE   = 1;
    localparam int B_BRK  = 2;
    localparam int B_ROE  = 3;
    localparam int B_TOE  = 4;
    localparam int B_TMT  = 5;
    localparam int B_TRDY = 6;
    localparam int B_RRDY = 7;
    localparam int B_EXC  = 8;
    localparam int B_TBRK = 9;
    localparam int B_DCTS = 10;
    localparam int B_CTS  = 11;
    localparam int B_EOP  = 12;

    localparam logic [2:0] A_RXD  = 3'd0;
    localparam logic [2:0] A_TXD  = 3'd1;
    localparam logic [2:0] A_STAT = 3'd2;
    localparam logic [2:0] A_CTRL = 3'd3;
    localparam logic [2:0] A_DIV  = 3'd4;
    localparam logic [2:0] A_EOP  = 3'd5;
endpackage

// File: rtl/uart_mm_rx.sv
module uart_mm_rx
    import uart_mm_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int DIV_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DIV_W-1:0]  div,
    input  logic              rxd,
    output logic              done,
    output logic [DATA_W-1:0] data,
    output logic              stop_ok
);
    localparam int IDX_W = $clog2(DATA_W);

    rx_state_t          state, state_nx;
    logic [1:0]         sync;
    logic               line;
    logic [DIV_W-1:0]   cnt;
    logic [IDX_W-1:0]   idx;
    logic               tick;

    assign line = sync[1];
    assign tick = (cnt == '0);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync <= 2'b11;
        else        sync <= {sync[0], rxd};
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            RX_IDLE:  if (!line) state_nx = RX_START;
            RX_START: if (tick) state_nx = line ? RX_IDLE : RX_DATA;
            RX_DATA:  if (tick && idx == IDX_W'(DATA_W - 1)) state_nx = RX_STOP;
            RX_STOP:  if (tick) state_nx = line ? RX_IDLE : RX_HOLD;
            RX_HOLD:  if (line) state_nx = RX_IDLE;
            default:  state_nx = RX_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= RX_IDLE;
        else        state <= state_nx;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt     <= '0;
            idx     <= '0;
            data    <= '0;
            done    <= 1'b0;
            stop_ok <= 1'b1;
        end else begin
            done <= 1'b0;
            if (!tick) cnt <= cnt - 1'b1;
            unique case (state)
                RX_IDLE:  begin
                    cnt <= div >> 1;
                    idx <= '0;
                end
                RX_START: if (tick) cnt <= div - 1'b1;
                RX_DATA:  if (tick) begin
                    data <= {line, data[DATA_W-1:1]};
                    idx  <= idx + 1'b1;
                    cnt  <= div - 1'b1;
                end
                RX_STOP:  if (tick) begin
                    done    <= 1'b1;
                    stop_ok <= line;
                end
                RX_HOLD:  ;
                default:  ;
            endcase
        end
    end

    p_hold_low_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (state == RX_HOLD && !line) |=> (state == RX_HOLD));
    p_done_once_r2: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
endmodule

// File: rtl/uart_mm_tx.sv
module uart_mm_tx
    import uart_mm_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int DIV_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DIV_W-1:0]  div,
    input  logic              load,
    input  logic [DATA_W-1:0] load_data,
    output logic              line,
    output logic              idle
);
    localparam int IDX_W = $clog2(DATA_W);

    tx_state_t          state, state_nx;
    logic [DIV_W-1:0]   cnt;
    logic [IDX_W-1:0]   idx;
    logic [DATA_W-1:0]  sh;
    logic               tick;

    assign tick = (cnt == '0);
    assign idle = (state == TX_IDLE);

    always_comb begin
        state_nx = state;
        unique case (state)
            TX_IDLE:  if (load) state_nx = TX_START;
            TX_START: if (tick) state_nx = TX_DATA;
            TX_DATA:  if (tick && idx == IDX_W'(DATA_W - 1)) state_nx = TX_STOP;
            TX_STOP:  if (tick) state_nx = TX_IDLE;
            default:  state_nx = TX_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= TX_IDLE;
        else        state <= state_nx;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt  <= '0;
            idx  <= '0;
            sh   <= '0;
            line <= 1'b1;
        end else begin
            if (!tick) cnt <= cnt - 1'b1;
            unique case (state)
                TX_IDLE:  if (load) begin
                    sh   <= load_data;
                    line <= 1'b0;
                    cnt  <= div - 1'b1;
                    idx  <= '0;
                end
                TX_START: if (tick) begin
                    line <= sh[0];
                    sh   <= sh >> 1;
                    cnt  <= div - 1'b1;
                end
                TX_DATA:  if (tick) begin
                    cnt <= div - 1'b1;
                    idx <= idx + 1'b1;
                    if (idx == IDX_W'(DATA_W - 1)) begin
                        line <= 1'b1;
                    end else begin
                        line <= sh[0];
                        sh   <= sh >> 1;
                    end
                end
                TX_STOP:  ;
                default:  ;
            endcase
        end
    end

    p_idle_high_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (idle && !load) |=> line);
endmodule

// File: rtl/uart_mm_top.sv
module uart_mm_top
    import uart_mm_pkg::*;
#(
    parameter int DATA_W    = 8,
    parameter int DIV_W     = 16,
    parameter int DIV_RESET = 16
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [4:0]  bus_addr,
    input  logic        bus_wr,
    input  logic        bus_rd,
    input  logic [31:0] bus_wdata,
    output logic [31:0] bus_rdata,
    output logic        irq,
    input  logic        rxd,
    output logic        txd,
    input  logic        cts,
    output logic        rts
);
    logic [2:0]        widx;
    logic [STAT_W-1:0] ctrl, stat;
    logic [DIV_W-1:0]  div;
    logic [DATA_W-1:0] eop_chr, rx_hold, tx_hold, rx_byte;
    logic              rrdy, tx_full, fe, brk, roe, toe, dcts, eop_ev;
    logic              rx_done, rx_stop_ok, tx_line, tx_idle, tx_load;
    logic [2:0]        cts_sync;
    logic              wr_tx, wr_st, rd_rx;

    assign widx  = bus_addr[4:2];
    assign wr_tx = bus_wr && widx == A_TXD;
    assign wr_st = bus_wr && widx == A_STAT;
    assign rd_rx = bus_rd && widx == A_RXD;

    uart_mm_rx #(.DATA_W(DATA_W), .DIV_W(DIV_W)) i_rx (
        .clk(clk), .rst_n(rst_n), .div(div), .rxd(rxd),
        .done(rx_done), .data(rx_byte), .stop_ok(rx_stop_ok));

    assign tx_load = tx_full && tx_idle;

    uart_mm_tx #(.DATA_W(DATA_W), .DIV_W(DIV_W)) i_tx (
        .clk(clk), .rst_n(rst_n), .div(div), .load(tx_load),
        .load_data(tx_hold), .line(tx_line), .idle(tx_idle));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cts_sync <= '0;
        else        cts_sync <= {cts_sync[1:0], cts};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl    <= '0;
            div     <= DIV_W'(DIV_RESET);
            eop_chr <= '0;
            rx_hold <= '0;
            tx_hold <= '0;
            rrdy    <= 1'b0;
            tx_full <= 1'b0;
            {fe, brk, roe, toe, dcts, eop_ev} <= '0;
        end else begin
            if (bus_wr && widx == A_CTRL) ctrl    <= bus_wdata[STAT_W-1:0];
            if (bus_wr && widx == A_DIV)  div     <= bus_wdata[DIV_W-1:0];
            if (bus_wr && widx == A_EOP)  eop_chr <= bus_wdata[DATA_W-1:0];
            if (wr_st) {fe, brk, roe, toe, dcts, eop_ev} <= '0;
            if (rd_rx) rrdy <= 1'b0;
            if (tx_load) tx_full <= 1'b0;
            if (wr_tx) begin
                if (tx_full) toe <= 1'b1;
                else begin
                    tx_hold <= bus_wdata[DATA_W-1:0];
                    tx_full <= 1'b1;
                end
            end
            if (cts_sync[2] != cts_sync[1]) dcts <= 1'b1;
            if (rx_done) begin
                rx_hold <= rx_byte;
                rrdy    <= 1'b1;
                if (rrdy && !rd_rx) roe <= 1'b1;
                if (rx_byte == eop_chr) eop_ev <= 1'b1;
                if (!rx_stop_ok) begin
                    if (rx_byte == '0) brk <= 1'b1;
                    else               fe  <= 1'b1;
                end
            end
        end
    end

    always_comb begin
        stat         = '0;
        stat[B_FE]   = fe;
        stat[B_BRK]  = brk;
        stat[B_ROE]  = roe;
        stat[B_TOE]  = toe;
        stat[B_TMT]  = !tx_full && tx_idle;
        stat[B_TRDY] = !tx_full;
        stat[B_RRDY] = rrdy;
        stat[B_EXC]  = fe | brk | roe | toe;
        stat[B_DCTS] = dcts;
        stat[B_CTS]  = cts_sync[1];
        stat[B_EOP]  = eop_ev;
    end

    always_comb begin
        bus_rdata = '0;
        unique case (widx)
            A_RXD:   bus_rdata[DATA_W-1:0] = rx_hold;
            A_STAT:  bus_rdata[STAT_W-1:0] = stat;
            A_CTRL:  bus_rdata[STAT_W-1:0] = ctrl;
            A_DIV:   bus_rdata[DIV_W-1:0]  = div;
            A_EOP:   bus_rdata[DATA_W-1:0] = eop_chr;
            default: bus_rdata = '0;
        endcase
    end

    assign irq = |(stat & ctrl & ~(STAT_W'(1) << B_TBRK) & ~(STAT_W'(1) << B_CTS));
    assign txd = tx_line && !ctrl[B_TBRK];
    assign rts = ctrl[B_CTS];

    p_read_clears_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_rx && !rx_done) |=> !rrdy);
    p_overrun_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_done && rrdy && !rd_rx) |=> (roe && rrdy));
    p_tx_overrun_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_tx && tx_full) |=> (toe && $stable(tx_hold)));
    p_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_st && !rx_done && !wr_tx) |=> (!fe && !brk && !roe && !toe));
    p_masked_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl == '0) |-> !irq);
    p_break_line_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $past(ctrl[B_TBRK]) && ctrl[B_TBRK] |-> !txd);
    p_cts_edge_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (cts_sync[2] != cts_sync[1]) |=> dcts);
endmodule

// File: tb/test_uart_mm_top.sv
module test_uart_mm_top;
    localparam int CLK_PERIOD = 10;
    localparam int BIT        = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [4:0]  bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq, txd, rts;
    logic        rxd = 1'b1;
    logic        cts = 1'b0;

    int checks = 0;
    int errors = 0;
    logic [7:0] cap [2];
    int         ncap = 0;

    uart_mm_top i_uart_mm_top (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .irq(irq), .rxd(rxd), .txd(txd), .cts(cts), .rts(rts));

    always #(CLK_PERIOD / 2) clk = ~clk;

    localparam logic [7:0] RX_VEC [4] = '{8'h55, 8'hA3, 8'h00, 8'hFF};

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [4:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [4:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic send(input logic [7:0] b, input logic stopb);
        @(negedge clk);
        rxd = 1'b0;
        repeat (BIT) @(negedge clk);
        for (int i = 0; i < 8; i++) begin
            rxd = b[i];
            repeat (BIT) @(negedge clk);
        end
        rxd = stopb;
        repeat (BIT) @(negedge clk);
        if (!stopb) repeat (3 * BIT) @(negedge clk);
        rxd = 1'b1;
        repeat (BIT) @(negedge clk);
    endtask

    task automatic capture();
        logic [7:0] b;
        @(negedge txd);
        repeat (BIT / 2) @(negedge clk);
        check("R4 start bit", {31'b0, txd}, 32'h0);
        for (int i = 0; i < 8; i++) begin
            repeat (BIT) @(negedge clk);
            b[i] = txd;
        end
        repeat (BIT) @(negedge clk);
        check("R4 stop bit", {31'b0, txd}, 32'h1);
        if (ncap < 2) cap[ncap] = b;
        ncap++;
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        errors++;
        checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [31:0] d;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // R1 reset state
        rd(5'd8, d);  check("R1 status", d, 32'h0060);
        rd(5'd12, d); check("R1 control", d, 32'h0);
        check("R1 irq/txd/rts", {29'b0, irq, txd, rts}, 32'h2);

        // R12 readback
        wr(5'd16, BIT); rd(5'd16, d); check("R12 divisor", d, BIT);
        wr(5'd20, 32'h7E); rd(5'd20, d); check("R12 eop", d, 32'h7E);

        // R2 table walk
        for (int v = 0; v < 4; v++) begin
            send(RX_VEC[v], 1'b1);
            rd(5'd8, d);  check("R2 rrdy set", d, 32'h00E0);
            rd(5'd0, d);  check("R2 data", d, {24'b0, RX_VEC[v]});
            rd(5'd8, d);  check("R2 rrdy cleared", d, 32'h0060);
        end

        // R8 irq on receive ready, masked by zero control
        wr(5'd12, 32'h80);
        send(8'h3C, 1'b1);
        check("R8 irq enabled", {31'b0, irq}, 32'h1);
        wr(5'd12, 32'h0);
        check("R8 irq masked", {31'b0, irq}, 32'h0);

        // R3 overrun
        send(8'h12, 1'b1);
        rd(5'd8, d); check("R3 overrun status", d, 32'h01E8);
        rd(5'd0, d); check("R3 overwritten data", d, 32'h12);
        wr(5'd8, 32'h0);
        rd(5'd8, d); check("R7 clear", d, 32'h0060);

        // R11 end-of-packet match
        send(8'h7E, 1'b1);
        rd(5'd8, d); check("R11 eop event", d, 32'h10E0);
        rd(5'd0, d);
        wr(5'd8, 32'h0);

        // R6 break then framing error
        send(8'h00, 1'b0);
        rd(5'd8, d); check("R6 break", d, 32'h01E4);
        rd(5'd0, d);
        wr(5'd8, 32'h0);
        send(8'h81, 1'b0);
        rd(5'd8, d); check("R6 framing", d, 32'h01E2);
        rd(5'd0, d); check("R6 framing data", d, 32'h81);
        wr(5'd8, 32'h0);
        rd(5'd8, d); check("R7 clear after framing", d, 32'h0060);

        // R4/R5 transmit with overrun
        fork
            begin capture(); capture(); end
        join_none
        @(negedge clk);
        bus_addr = 5'd4; bus_wr = 1'b1; bus_wdata = 32'hA5;
        @(negedge clk); bus_wdata = 32'h3C;
        @(negedge clk); bus_wdata = 32'h96;
        @(negedge clk); bus_wr = 1'b0;
        rd(5'd8, d); check("R5 trdy clear, toe", d, 32'h0110);
        repeat (25 * BIT) @(negedge clk);
        check("R4 two frames", ncap, 2);
        check("R4 first char", {24'b0, cap[0]}, 32'hA5);
        check("R5 dropped char", {24'b0, cap[1]}, 32'h96);
        rd(5'd8, d); check("R4 empty after", d, 32'h0170);
        wr(5'd8, 32'h0);
        rd(5'd8, d); check("R7 clears toe", d, 32'h0060);

        // R9 break and rts
        wr(5'd12, 32'h200);
        check("R9 break line", {31'b0, txd}, 32'h0);
        wr(5'd12, 32'h800);
        check("R9 rts/txd", {30'b0, rts, txd}, 32'h3);

        // R10 cts sync and change event
        wr(5'd12, 32'h400);
        cts = 1'b1;
        repeat (5) @(negedge clk);
        rd(5'd8, d); check("R10 cts level+change", d, 32'h0C60);
        check("R8 irq on cts change", {31'b0, irq}, 32'h1);
        wr(5'd8, 32'h0);
        rd(5'd8, d); check("R10 change cleared", d, 32'h0860);
        check("R8 irq drops", {31'b0, irq}, 32'h0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule